// File: doc/BRIEF.md
# Random Generator Control Register Bank

This block is the register front end of a hardware random number source. It sits on a 32-bit register bus with single-cycle accesses. A write sets control bits or issues one-cycle commands. A read returns identification, status, error or random data in the cycle it is presented. The self-test and seeding engines are modelled by a small sequencer. It holds the busy flag for a fixed number of cycles per operation and then raises a completion flag.

Failure-injection pins mark a run as failed: self-test, oscillator, shift-register and statistical failure. The failure is recorded in a sticky error register when the run finishes. An external FIFO reports its fill level and an error line, and supplies the data word returned at the data offset. A single level-sensitive interrupt combines the completion flags and the error summary, each group under its own mask bit.

The sequencer has three states:
- IDLE
- SELF_TEST
- SEEDING

Its transitions are:
- IDLE to SELF_TEST on a self-test command.
- IDLE to SEEDING on a seed command.
- SELF_TEST to SEEDING when auto-seed is enabled and the self-test finished without an injected failure (the auto-chain).
- SELF_TEST to IDLE on the other self-test completions.
- SEEDING to IDLE on completion.
- Any state to IDLE on software reset.

Top module: `rng_ctl_regs`

## Requirements
- R1: A read of offset 0x00 returns {type[31:28], 4'b0, chip version[23:16], 8'd3, minor version[7:0]}, with the type, chip and minor values set by parameters.
- R2: Command register (offset 0x04) bit map: bit0 starts a self-test, bit1 starts seeding, bit4 clears the done flags, bit5 clears the error register and bit6 is a software reset. The register always reads as zero, and a write that sets only other bits has no effect.
- R3: Control register (offset 0x08) bit map: bit4 enables auto-seed, bit5 masks the done interrupt and bit6 masks the error interrupt. Only these bits are stored; all others read as zero. The reset value is zero.
- R4: A self-test command in IDLE holds status bit1 (busy) high for exactly ST_CYCLES cycles and then sets status bit4 (self-test done).
- R5: A seed command in IDLE holds busy high for exactly SEED_CYCLES cycles and then sets status bit5 (seed done).
- R6: Start commands are ignored while busy. When both start bits are written together, only the self-test runs.
- R7: With auto-seed enabled, a self-test that ends without an injected failure continues straight into seeding. Busy stays high for ST_CYCLES+SEED_CYCLES cycles, and both done flags are then set.
- R8: Error register (offset 0x10) bit map: bit0 shift-register failure, bit1 oscillator failure, bit2 self-test failure, bit3 statistical failure, bit4 FIFO failure. At self-test completion the self-test, oscillator and shift-register inject pins set their bits. At seed completion the statistical and oscillator pins set theirs. Status bit16 is the OR of all error bits.
- R9: The FIFO error input sets error bit4 in the following cycle. Status bits 11:8 show the FIFO level input, and bits 15:12 show the FIFO_SIZE parameter.
- R10: The irq output is high when (self-test done or seed done) and the done mask is clear, or when the error summary is set and the error mask is clear.
- R11: Clear-done drops both done flags and clear-error drops all error bits on the next edge. A flag set by a completion in that same cycle survives the clear.
- R12: A software reset clears control, the done flags, the error register and the sequencer in one cycle. Any other command bits written with it are ignored.
- R13: A read of offset 0x14 returns the FIFO data input and raises fifo_pop for that cycle only. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| fifo_level | input | 4 | Current FIFO fill level |
| fifo_err | input | 1 | FIFO failure indication |
| fifo_data | input | 32 | Head word of the random data FIFO |
| fifo_pop | output | 1 | High during a read of the data offset |
| inj_osc | input | 1 | Inject oscillator failure |
| inj_lfsr | input | 1 | Inject shift-register failure |
| inj_stat | input | 1 | Inject statistical failure |
| inj_st | input | 1 | Inject self-test failure |
| irq | output | 1 | Level interrupt |

## Verification
The bench counts busy cycles read through the status register. A sequencer with an off-by-one counter would report ST_CYCLES±1, and a missing auto-chain would show only the self-test length. The bench writes a clear-done command that lands on the same edge as a self-test completion. A design that lets the clear win would drop the done flag and the interrupt, and the completion would be lost. Start commands issued during a run and a reserved-bits-only command write show whether stray writes restart or extend the sequencer. The bench also issues a software reset together with start bits; a design that decodes the start bits would go busy again.

// File: rtl/rng_ctl_pkg.sv
package rng_ctl_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SELF_TEST,
        S_SEEDING
    } seq_state_e;

    localparam int OFS_VER  = 'h00;
    localparam int OFS_CMD  = 'h04;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_STAT = 'h0C;
    localparam int OFS_ERR  = 'h10;
    localparam int OFS_FIFO = 'h14;

    localparam int CMD_ST      = 0;
    localparam int CMD_SEED    = 1;
    localparam int CMD_CLR_DN  = 4;
    localparam int CMD_CLR_ER  = 5;
    localparam int CMD_SW_RST  = 6;

    localparam int ERR_W    = 7;
    localparam int E_LFSR   = 0;
    localparam int E_OSC    = 1;
    localparam int E_ST     = 2;
    localparam int E_STAT   = 3;
    localparam int E_FIFO   = 4;

    localparam logic [7:0] MAJOR_VER = 8'd3;
endpackage

// File: rtl/rng_op_seq.sv
module rng_op_seq
    import rng_ctl_pkg::*;
#(
    parameter int ST_CYCLES   = 12,
    parameter int SEED_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic go_st,
    input  logic go_seed,
    input  logic auto_seed,
    input  logic st_bad,
    output logic busy,
    output logic st_fin,
    output logic seed_fin
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int MAXC  = (ST_CYCLES > SEED_CYCLES) ? ST_CYCLES : SEED_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] ST_LOAD   = CNT_W'(ST_CYCLES - 1);
    localparam logic [CNT_W-1:0] SEED_LOAD = CNT_W'(SEED_CYCLES - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (go_st) begin
                    state_d = S_SELF_TEST;
                    cnt_d   = ST_LOAD;
                end else if (go_seed) begin
                    state_d = S_SEEDING;
                    cnt_d   = SEED_LOAD;
                end
            end
            S_SELF_TEST: begin
                if (cnt_q == '0) begin
                    if (auto_seed && !st_bad) begin
                        state_d = S_SEEDING;
                        cnt_d   = SEED_LOAD;
                    end else begin
                        state_d = S_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            S_SEEDING: begin
                if (cnt_q == '0) state_d = S_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = S_IDLE;
        endcase
        if (sw_rst) begin
            state_d = S_IDLE;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        busy     = 1'b0;
        st_fin   = 1'b0;
        seed_fin = 1'b0;
        unique case (state_q)
            S_IDLE:      ;
            S_SELF_TEST: begin
                busy   = 1'b1;
                st_fin = (cnt_q == '0);
            end
            S_SEEDING: begin
                busy     = 1'b1;
                seed_fin = (cnt_q == '0);
            end
            default: ;
        endcase
    end

    // R4
    st_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SELF_TEST && cnt_q != '0 && !sw_rst)
        |=> (state_q == S_SELF_TEST) && (cnt_q == $past(cnt_q) - 1'b1));

    // R6
    seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SEEDING && cnt_q != '0 && !sw_rst) |=> (state_q == S_SEEDING));
endmodule

// File: rtl/rng_err_track.sv
module rng_err_track
    import rng_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             clr,
    input  logic             st_fin,
    input  logic             seed_fin,
    input  logic             inj_osc,
    input  logic             inj_lfsr,
    input  logic             inj_stat,
    input  logic             inj_st,
    input  logic             fifo_err,
    output logic [ERR_W-1:0] err_q
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [ERR_W-1:0] set_v;

    always_comb begin
        set_v = '0;
        if (st_fin) begin
            set_v[E_ST]   = inj_st;
            set_v[E_OSC]  = inj_osc;
            set_v[E_LFSR] = inj_lfsr;
        end
        if (seed_fin) begin
            set_v[E_STAT] = inj_stat;
            set_v[E_OSC]  = set_v[E_OSC] | inj_osc;
        end
        set_v[E_FIFO] = fifo_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      err_q <= '0;
        else if (sw_rst) err_q <= '0;
        else             err_q <= (clr ? '0 : err_q) | set_v;
    end

    // R8
    st_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q[E_ST]) |-> $past(st_fin && inj_st));
endmodule

// File: rtl/rng_ctl_regs.sv
module rng_ctl_regs
    import rng_ctl_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter int         ST_CYCLES   = 12,
    parameter int         SEED_CYCLES = 20,
    parameter logic [3:0] FIFO_SIZE   = 4'd15,
    parameter logic [3:0] GEN_TYPE    = 4'd1,
    parameter logic [7:0] CHIP_VER    = 8'h10,
    parameter logic [7:0] MINOR_VER   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        fifo_level,
    input  logic              fifo_err,
    input  logic [31:0]       fifo_data,
    output logic              fifo_pop,
    input  logic              inj_osc,
    input  logic              inj_lfsr,
    input  logic              inj_stat,
    input  logic              inj_st,
    output logic              irq
);
    timeunit 1ns;
    timeprecision 100ps;

    logic             wr_cmd, wr_ctrl;
    logic             sw_rst, clr_dn, clr_er;
    logic [2:0]       ctrl_q;     // [0] auto-seed, [1] done mask, [2] error mask
    logic             st_done_q, seed_done_q;
    logic             busy, st_fin, seed_fin;
    logic [ERR_W-1:0] err_q;
    logic             err_sum;

    assign wr_cmd  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign sw_rst  = wr_cmd && bus_wdata[CMD_SW_RST];
    assign clr_dn  = wr_cmd && bus_wdata[CMD_CLR_DN];
    assign clr_er  = wr_cmd && bus_wdata[CMD_CLR_ER];

    rng_op_seq #(
        .ST_CYCLES  (ST_CYCLES),
        .SEED_CYCLES(SEED_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .go_st    (wr_cmd && bus_wdata[CMD_ST]),
        .go_seed  (wr_cmd && bus_wdata[CMD_SEED]),
        .auto_seed(ctrl_q[0]),
        .st_bad   (inj_st | inj_osc | inj_lfsr),
        .busy     (busy),
        .st_fin   (st_fin),
        .seed_fin (seed_fin)
    );

    rng_err_track u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_rst  (sw_rst),
        .clr     (clr_er),
        .st_fin  (st_fin),
        .seed_fin(seed_fin),
        .inj_osc (inj_osc),
        .inj_lfsr(inj_lfsr),
        .inj_stat(inj_stat),
        .inj_st  (inj_st),
        .fifo_err(fifo_err),
        .err_q   (err_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            st_done_q   <= 1'b0;
            seed_done_q <= 1'b0;
        end else if (sw_rst) begin
            ctrl_q      <= '0;
            st_done_q   <= 1'b0;
            seed_done_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[6:4];
            st_done_q   <= st_fin   | (st_done_q   & ~clr_dn);
            seed_done_q <= seed_fin | (seed_done_q & ~clr_dn);
        end
    end

    assign err_sum = |err_q;
    assign irq     = ((st_done_q | seed_done_q) & ~ctrl_q[1]) | (err_sum & ~ctrl_q[2]);

    always_comb begin
        bus_rdata = '0;
        fifo_pop  = 1'b0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_W'(OFS_VER):  bus_rdata = {GEN_TYPE, 4'b0, CHIP_VER, MAJOR_VER, MINOR_VER};
                ADDR_W'(OFS_CTRL): bus_rdata = {25'b0, ctrl_q, 4'b0};
                ADDR_W'(OFS_STAT): bus_rdata = {15'b0, err_sum, FIFO_SIZE, fifo_level,
                                                2'b0, seed_done_q, st_done_q, 2'b0, busy, 1'b0};
                ADDR_W'(OFS_ERR):  bus_rdata = {{(32-ERR_W){1'b0}}, err_q};
                ADDR_W'(OFS_FIFO): begin
                    bus_rdata = fifo_data;
                    fifo_pop  = 1'b1;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R12
    sw_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (ctrl_q == '0) && !busy && !irq);

    // R11
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_er && !fifo_err && !st_fin && !seed_fin) |=> (err_q == '0));

    // R5
    seed_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_fin && !sw_rst) |=> seed_done_q);
endmodule

// File: tb/sim_rng_ctl_regs.sv
module sim_rng_ctl_regs;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int ST_N   = 6;
    localparam int SEED_N = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [3:0]  fifo_level = 4'h3;
    logic        fifo_err = 1'b0;
    logic [31:0] fifo_data = 32'hA5C3_1E77;
    logic        fifo_pop, irq;
    logic        inj_osc = 1'b0, inj_lfsr = 1'b0, inj_stat = 1'b0, inj_st = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    rng_ctl_regs #(
        .ADDR_W(8), .ST_CYCLES(ST_N), .SEED_CYCLES(SEED_N),
        .FIFO_SIZE(4'h8), .GEN_TYPE(4'h2), .CHIP_VER(8'h11), .MINOR_VER(8'h05)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_level(fifo_level), .fifo_err(fifo_err), .fifo_data(fifo_data),
        .fifo_pop(fifo_pop), .inj_osc(inj_osc), .inj_lfsr(inj_lfsr),
        .inj_stat(inj_stat), .inj_st(inj_st), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard for every read cycle the driver queued
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_sel && !bus_wr && exp_q.size() != 0) begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
                check(fifo_pop === (bus_addr == 8'h14), "R13 fifo_pop", {31'b0, fifo_pop},
                      {31'b0, bus_addr == 8'h14});
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0;
        end
    endtask

    task automatic irq_is(input logic e, input string t);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
        check(irq === e, t, {31'b0, irq}, {31'b0, e});
    endtask

    task automatic busy_len(input int e, input string t);
        int n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h0C;
            #1;
            if (!bus_rdata[1]) break;
            n++;
        end
        check(n == e, t, n, e);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state
        rd(8'h00, 32'h2011_0305, "R1 version");
        rd(8'h0C, 32'h0000_8300, "R9 status after reset");
        rd(8'h08, 32'h0, "R3 control reset");
        rd(8'h10, 32'h0, "R8 error reset");
        rd(8'h04, 32'h0, "R2 command reads zero");
        irq_is(1'b0, "R10 irq after reset");
        // R3 control storage
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0000_0070, "R3 only bits 6:4 stored");
        wr(8'h08, 32'h0);
        rd(8'h08, 32'h0, "R3 control cleared");
        // R2 reserved command bits
        wr(8'h04, 32'hFFFF_FF8C);
        rd(8'h04, 32'h0, "R2 command readback");
        rd(8'h0C, 32'h0000_8300, "R2 reserved bits no effect");
        // R4 self-test
        wr(8'h04, 32'h1);
        busy_len(ST_N, "R4 self-test busy length");
        rd(8'h0C, 32'h0000_8310, "R4 self-test done");
        irq_is(1'b1, "R10 irq on done");
        wr(8'h08, 32'h20);
        irq_is(1'b0, "R10 done masked");
        wr(8'h08, 32'h0);
        irq_is(1'b1, "R10 done unmasked");
        wr(8'h04, 32'h10);
        rd(8'h0C, 32'h0000_8300, "R11 clear done");
        irq_is(1'b0, "R11 irq dropped");
        // R5 seed
        wr(8'h04, 32'h2);
        busy_len(SEED_N, "R5 seed busy length");
        rd(8'h0C, 32'h0000_8320, "R5 seed done");
        // R6 both bits: self-test only
        wr(8'h04, 32'h10);
        wr(8'h04, 32'h3);
        busy_len(ST_N, "R6 both starts run self-test");
        rd(8'h0C, 32'h0000_8310, "R6 no seed after both");
        // R6 starts ignored while busy
        wr(8'h04, 32'h10);
        wr(8'h04, 32'h1);
        wr(8'h04, 32'h2);
        busy_len(ST_N - 1, "R6 start while busy ignored");
        idle(12);
        rd(8'h0C, 32'h0000_8310, "R6 seed never ran");
        // R7 auto-seed
        wr(8'h04, 32'h10);
        wr(8'h08, 32'h10);
        wr(8'h04, 32'h1);
        busy_len(ST_N + SEED_N, "R7 auto chain busy length");
        rd(8'h0C, 32'h0000_8330, "R7 both done");
        // R8 self-test failure, no chain
        wr(8'h04, 32'h30);
        inj_st = 1'b1;
        wr(8'h04, 32'h1);
        busy_len(ST_N, "R8 failed self-test does not chain");
        rd(8'h10, 32'h0000_0004, "R8 self-test error bit");
        rd(8'h0C, 32'h0001_8310, "R8 error summary");
        inj_st = 1'b0;
        wr(8'h04, 32'h30);
        inj_stat = 1'b1; inj_osc = 1'b1;
        wr(8'h04, 32'h2);
        busy_len(SEED_N, "R8 seed with failures");
        rd(8'h10, 32'h0000_000A, "R8 statistical and oscillator bits");
        rd(8'h0C, 32'h0001_8320, "R8 summary after seed");
        inj_stat = 1'b0; inj_osc = 1'b0;
        wr(8'h08, 32'h50);
        irq_is(1'b1, "R10 done still raises irq");
        wr(8'h08, 32'h70);
        irq_is(1'b0, "R10 both masked");
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h20);
        rd(8'h10, 32'h0, "R11 clear error");
        rd(8'h0C, 32'h0000_8320, "R11 clear error keeps done");
        wr(8'h04, 32'h10);
        // R9 FIFO error and level
        @(negedge clk); bus_sel = 1'b0; fifo_err = 1'b1;
        @(negedge clk); fifo_err = 1'b0;
        fifo_level = 4'hF;
        rd(8'h10, 32'h0000_0010, "R9 fifo error bit");
        rd(8'h0C, 32'h0001_8F00, "R9 level and summary");
        irq_is(1'b1, "R10 irq on error");
        wr(8'h04, 32'h30);
        rd(8'h0C, 32'h0000_8F00, "R9 cleared");
        // R11 collision: clear lands on completion edge
        wr(8'h04, 32'h1);
        idle(ST_N - 1);
        wr(8'h04, 32'h10);
        rd(8'h0C, 32'h0000_8F10, "R11 completion beats clear");
        wr(8'h04, 32'h10);
        // R13 data path
        rd(8'h14, 32'hA5C3_1E77, "R13 fifo data");
        rd(8'h20, 32'h0, "R13 unmapped offset");
        // R12 software reset
        wr(8'h08, 32'h70);
        wr(8'h04, 32'h1);
        idle(2);
        wr(8'h04, 32'h43);
        rd(8'h0C, 32'h0000_8F00, "R12 status after reset");
        rd(8'h08, 32'h0, "R12 control after reset");
        irq_is(1'b0, "R12 irq after reset");
        busy_len(0, "R12 start bits ignored");
        idle(3);
        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule